// File: doc/BRIEF.md
# Packed-Lane Integer ALU with Byte Write Mask

This block is a 32-bit integer ALU slice that executes one operation per cycle on packed lanes of 8, 16 or 32 bits. The lane width is a run-time input, so a single datapath serves all three element sizes. Operand bytes arrive already placed in the byte positions they will occupy in the destination register. The result is therefore never moved between lanes and can be written straight into a register-file bank.

Alongside the 32-bit result the block produces a 4-bit byte write enable. It is formed from the lane width, one predicate bit per element and the count of elements still remaining in the vector. Disabled elements leave their destination bytes untouched. Narrow results are neither sign-extended nor zero-extended. The operation set is add, subtract, and, or, xor, and left and right shifts. Inputs are captured with a valid strobe, and results leave a register stage one cycle later.

Top module: `simd_alu`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `valid_o`, `result_o` and `byte_we_o` for that operation are presented after exactly that edge. `valid_o` is low after any edge where `valid_i` was low.
- R2: `ew_i` selects the lane width: 00 = 8-bit (four lanes), 01 = 16-bit (two lanes), 10 = 32-bit (one lane). Lane k occupies bits [k*W +: W]. Add (`op_i` = 000) wraps modulo 2^W in each lane, with no carry crossing a lane boundary.
- R3: Subtract (`op_i` = 001) computes a − b modulo 2^W in each lane, with no borrow crossing a lane boundary.
- R4: And (010), or (011) and xor (100) act bitwise on the full 32 bits at every valid lane width.
- R5: Shift left (101) and logical shift right (110) shift each lane independently. The shift amount is the low log2(W) bits of the same lane of `b_i`, which makes it the shift count modulo W. Vacated bits are filled with zeros.
- R6: Arithmetic shift right (111) fills each lane's vacated bits with that lane's own top bit.
- R7: Element k is enabled when `pred_i[k]` is 1 and k < `vl_i`. An enabled element sets every byte-enable bit of its bytes, [k*W/8 +: W/8]. All other bits are 0. Predicate bits above the element count are ignored.
- R8: The reserved width code `ew_i` = 11 yields `byte_we_o` = 0 and `result_o` = 0.
- R9: `result_o` holds the computed value in every lane, including lanes whose write enable is 0. Narrow results are never extended into neighbouring bytes.
- R10: During reset, and after any edge with `valid_i` low, `valid_o` and `byte_we_o` are 0. During reset `result_o` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (see R2–R6) |
| ew_i | input | 2 | Lane width code |
| a_i | input | 32 | First operand, lane aligned |
| b_i | input | 32 | Second operand or shift counts, lane aligned |
| pred_i | input | 4 | Per-element predicate |
| vl_i | input | 3 | Elements remaining in the vector |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Lane-wise result |
| byte_we_o | output | 4 | Byte write enable for the register bank |

## Verification
Every result, mask and valid flag is due exactly one rising edge after the inputs are accepted. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs against a behavioural model evaluated from the inputs it applied one cycle earlier. Idle cycles are compared as well, to confirm that the valid flag and mask drop. The stimulus includes directed lane-boundary cases for carry, borrow, shift count wrap and sign fill, as well as predicate and length patterns at each width. Back-to-back and gapped random traffic complete the set.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLL = 3'd5,
    OP_SRL = 3'd6,
    OP_SRA = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    EW_8    = 2'd0,
    EW_16   = 2'd1,
    EW_32   = 2'd2,
    EW_RSVD = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } sh_kind_e;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  ew_e          ew_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned NB = W / BYTE_W;

  logic [W-1:0]  b_x;
  logic [NB-1:0] cout;
  logic [NB-1:0] cin;

  assign b_x = sub_i ? ~b_i : b_i;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic lane_start;
    logic [BYTE_W:0] part;
    // carry chain breaks where a new lane begins
    if (j % 4 == 0) begin : g_w32
      assign lane_start = 1'b1;
    end else if (j % 2 == 0) begin : g_w16
      assign lane_start = (ew_i == EW_8) || (ew_i == EW_16);
    end else begin : g_w8
      assign lane_start = (ew_i == EW_8);
    end
    if (j == 0) begin : g_first
      assign cin[j] = sub_i;
    end else begin : g_rest
      assign cin[j] = lane_start ? sub_i : cout[j-1];
    end
    assign part = {1'b0, a_i[j*BYTE_W +: BYTE_W]} + {1'b0, b_x[j*BYTE_W +: BYTE_W]}
                + {{BYTE_W{1'b0}}, cin[j]};
    assign cout[j] = part[BYTE_W];
    assign sum_o[j*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
  end
endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift
  import simd_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] amt_i,
  input  sh_kind_e      kind_i,
  output logic [W-1:0]  y_o
);
  always_comb begin
    unique case (kind_i)
      SH_LEFT:  y_o = x_i << amt_i;
      SH_RIGHT: y_o = x_i >> amt_i;
      SH_ARITH: y_o = W'($signed(x_i) >>> amt_i);
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_shift.sv
module simd_shift
  import simd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sh_kind_e     kind_i,
  input  ew_e          ew_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned N8  = W / 8;
  localparam int unsigned N16 = W / 16;
  localparam int unsigned N32 = W / 32;

  logic [W-1:0] y8, y16, y32;
  logic unused_b;
  assign unused_b = ^b_i;

  for (genvar l = 0; l < N8; l++) begin : g_l8
    simd_lane_shift #(.W(8)) u_sh (
      .x_i(a_i[l*8 +: 8]), .amt_i(b_i[l*8 +: 3]), .kind_i(kind_i), .y_o(y8[l*8 +: 8]));
  end
  for (genvar l = 0; l < N16; l++) begin : g_l16
    simd_lane_shift #(.W(16)) u_sh (
      .x_i(a_i[l*16 +: 16]), .amt_i(b_i[l*16 +: 4]), .kind_i(kind_i), .y_o(y16[l*16 +: 16]));
  end
  for (genvar l = 0; l < N32; l++) begin : g_l32
    simd_lane_shift #(.W(32)) u_sh (
      .x_i(a_i[l*32 +: 32]), .amt_i(b_i[l*32 +: 5]), .kind_i(kind_i), .y_o(y32[l*32 +: 32]));
  end

  always_comb begin
    unique case (ew_i)
      EW_8:    y_o = y8;
      EW_16:   y_o = y16;
      EW_32:   y_o = y32;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_mask.sv
module simd_mask
  import simd_pkg::*;
#(
  parameter int unsigned NB   = NBYTES,
  parameter int unsigned VL_W = 3
) (
  input  ew_e             ew_i,
  input  logic [NB-1:0]   pred_i,
  input  logic [VL_W-1:0] vl_i,
  output logic [NB-1:0]   we_o
);
  always_comb begin
    we_o = '0;
    for (int j = 0; j < NB; j++) begin
      int unsigned elem;
      elem = 0;
      unique case (ew_i)
        EW_8:    elem = j;
        EW_16:   elem = j / 2;
        EW_32:   elem = j / 4;
        default: elem = 0;
      endcase
      if (ew_i != EW_RSVD)
        we_o[j] = pred_i[elem] && (elem < int'(vl_i));
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int unsigned VL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        ew_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [NBYTES-1:0] pred_i,
  input  logic [VL_W-1:0]   vl_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [NBYTES-1:0] byte_we_o
);
  alu_op_e op;
  ew_e     ew;
  sh_kind_e sh_kind;
  logic [DATA_W-1:0] sum, shf, res_d;
  logic [NBYTES-1:0] we_d;

  assign op = alu_op_e'(op_i);
  assign ew = ew_e'(ew_i);

  always_comb begin
    unique case (op)
      OP_SLL:  sh_kind = SH_LEFT;
      OP_SRL:  sh_kind = SH_RIGHT;
      default: sh_kind = SH_ARITH;
    endcase
  end

  simd_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(op == OP_SUB), .ew_i(ew), .sum_o(sum));

  simd_shift #(.W(DATA_W)) u_shift (
    .a_i(a_i), .b_i(b_i), .kind_i(sh_kind), .ew_i(ew), .y_o(shf));

  simd_mask #(.NB(NBYTES), .VL_W(VL_W)) u_mask (
    .ew_i(ew), .pred_i(pred_i), .vl_i(vl_i), .we_o(we_d));

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         res_d = sum;
      OP_AND:                 res_d = a_i & b_i;
      OP_OR:                  res_d = a_i | b_i;
      OP_XOR:                 res_d = a_i ^ b_i;
      OP_SLL, OP_SRL, OP_SRA: res_d = shf;
      default:                res_d = '0;
    endcase
    if (ew == EW_RSVD) res_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      byte_we_o <= '0;
    end else begin
      valid_o   <= valid_i;
      byte_we_o <= valid_i ? we_d : '0;
      if (valid_i) result_o <= res_d;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && byte_we_o == '0));
  a_r8_rsvd_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ew_i == 2'b11) |=> (byte_we_o == '0 && result_o == '0));
  a_r7_pred_off_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0) |=> byte_we_o == '0);
  a_r7_half_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ew_i == 2'b01) |=> (byte_we_o[0] == byte_we_o[1] && byte_we_o[2] == byte_we_o[3]));
  a_r2_word_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0 && ew_i == 2'b10) |=> result_o == ($past(a_i) + $past(b_i)));
  a_r2_byte0_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0 && ew_i == 2'b00) |=> result_o[7:0] == ($past(a_i[7:0]) + $past(b_i[7:0])));
  a_r4_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && ew_i != 2'b11) |=> result_o == ($past(a_i) ^ $past(b_i)));
endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  ew_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [3:0]  pred_i = '0;
  logic [2:0]  vl_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  byte_we_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic        q_v[$];
  logic [31:0] q_r[$];
  logic [3:0]  q_m[$];
  string       q_t[$];

  always #5 clk_i = ~clk_i;

  simd_alu u_simd_alu (.*);

  function automatic logic [31:0] ref_result(int op, int ew, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    longint x, y, z, lim;
    int w, sh;
    if (ew == 3) return 32'h0;
    w = 8 << ew;
    lim = longint'(1) << w;
    r = 32'h0;
    for (int l = 0; l < 32 / w; l++) begin
      x = (longint'(a) >> (l * w)) & (lim - 1);
      y = (longint'(b) >> (l * w)) & (lim - 1);
      sh = int'(y % w);
      case (op)
        0: z = x + y;
        1: z = x - y + lim;
        2: z = x & y;
        3: z = x | y;
        4: z = x ^ y;
        5: z = x << sh;
        6: z = x >> sh;
        default: begin
          if (x >= lim / 2) x = x - lim;
          z = x >>> sh;
        end
      endcase
      r = r | 32'((z & (lim - 1)) << (l * w));
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_mask(int ew, logic [3:0] pred, int vl);
    logic [3:0] m;
    int bpe;
    m = 4'h0;
    if (ew == 3) return m;
    bpe = 1 << ew;
    for (int k = 0; k < 4 / bpe; k++)
      if (pred[k] && k < vl)
        for (int j = 0; j < bpe; j++) m[k * bpe + j] = 1'b1;
    return m;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_one(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    logic v; logic [31:0] r; logic [3:0] m; string t;
    if (q_v.size() == 0) return;
    v = q_v.pop_front(); r = q_r.pop_front(); m = q_m.pop_front(); t = q_t.pop_front();
    check_one("R1", "valid_o", 32'(valid_o), 32'(v));
    if (v) begin
      check_one(t, "result_o", result_o, r);
      check_one((t == "R8") ? "R8" : "R7", "byte_we_o", 32'(byte_we_o), 32'(m));
    end else begin
      check_one("R10", "byte_we_o idle", 32'(byte_we_o), 32'h0);
    end
  endtask

  task automatic step(bit v, int op, int ew, logic [31:0] a, logic [31:0] b,
                      logic [3:0] p, int vl, string tag);
    @(negedge clk_i);
    compare_pending();
    valid_i = v; op_i = 3'(op); ew_i = 2'(ew); a_i = a; b_i = b; pred_i = p; vl_i = 3'(vl);
    q_v.push_back(v);
    q_r.push_back(ref_result(op, ew, a, b));
    q_m.push_back(ref_mask(ew, p, vl));
    q_t.push_back(tag == "" ? op_tag(op) : tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check_one("R10", "valid_o in reset", 32'(valid_o), 32'h0);
    check_one("R10", "byte_we_o in reset", 32'(byte_we_o), 32'h0);
    check_one("R10", "result_o in reset", result_o, 32'h0);
    rst_ni = 1'b1;

    // R2 lane-isolated carries
    step(1, 0, 0, 32'h80FF7F01, 32'h80017F01, 4'hF, 4, "R2");
    step(1, 0, 1, 32'hFFFF8000, 32'h00018000, 4'h3, 4, "R2");
    step(1, 0, 2, 32'hFFFFFFFF, 32'h00000001, 4'h1, 1, "R2");
    // R3 lane-isolated borrows
    step(1, 1, 0, 32'h00000000, 32'h01010101, 4'hF, 4, "R3");
    step(1, 1, 1, 32'h00010000, 32'h00010001, 4'h3, 2, "R3");
    step(1, 1, 2, 32'h00000000, 32'h00000001, 4'h1, 1, "R3");
    // R4 logic at each width
    step(1, 2, 0, 32'hF0F0A5A5, 32'hFF00FF00, 4'hF, 4, "R4");
    step(1, 3, 1, 32'h12340000, 32'h0000ABCD, 4'h3, 4, "R4");
    step(1, 4, 2, 32'hDEADBEEF, 32'hFFFF0000, 4'h1, 4, "R4");
    // R5 shift counts wrap per lane
    step(1, 5, 0, 32'h81818181, 32'h09010807, 4'hF, 4, "R5");
    step(1, 6, 1, 32'h80008000, 32'h00110004, 4'h3, 4, "R5");
    step(1, 5, 2, 32'h00000001, 32'h00000021, 4'h1, 4, "R5");
    // R6 sign fill per lane
    step(1, 7, 0, 32'h807F80FF, 32'h03030707, 4'hF, 4, "R6");
    step(1, 7, 1, 32'h80007FFF, 32'h000F000F, 4'h3, 4, "R6");
    step(1, 7, 2, 32'h80000000, 32'h0000001F, 4'h1, 4, "R6");
    // R7 predicate / length patterns
    step(1, 0, 0, 32'h11223344, 32'h01010101, 4'b1010, 4, "R7");
    step(1, 0, 0, 32'h11223344, 32'h01010101, 4'hF, 2, "R7");
    step(1, 0, 1, 32'h11223344, 32'h01010101, 4'b1110, 4, "R7");
    step(1, 0, 1, 32'h11223344, 32'h01010101, 4'hF, 1, "R7");
    step(1, 0, 2, 32'h11223344, 32'h01010101, 4'hE, 4, "R7");
    step(1, 0, 2, 32'h11223344, 32'h01010101, 4'h1, 0, "R7");
    // R8 reserved width
    step(1, 0, 3, 32'h11223344, 32'h55667788, 4'hF, 7, "R8");
    step(1, 4, 3, 32'hFFFFFFFF, 32'h0F0F0F0F, 4'hF, 4, "R8");
    // R9 masked lanes still carry results, no extension
    step(1, 0, 0, 32'h7F7F7F7F, 32'h01010101, 4'h0, 4, "R9");
    step(1, 1, 1, 32'h00000000, 32'h00010001, 4'h1, 1, "R9");
    // R1 / R10 gaps and back-to-back
    step(0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'hF, 4, "R10");
    step(1, 0, 2, 32'h00000005, 32'h00000007, 4'h1, 1, "R1");
    step(0, 4, 2, 32'h0, 32'h0, 4'hF, 4, "R10");
    step(0, 4, 2, 32'h0, 32'h0, 4'hF, 4, "R10");

    for (int i = 0; i < 400; i++) begin
      int op, ew;
      op = int'($urandom_range(0, 7));
      ew = int'($urandom_range(0, 3));
      step(($urandom_range(0, 4) != 0), op, ew, $urandom, $urandom,
           4'($urandom), int'($urandom_range(0, 7)), (ew == 3) ? "R8" : "");
    end
    step(0, 0, 0, 32'h0, 32'h0, 4'h0, 0, "R10");
    @(negedge clk_i);
    compare_pending();
    finish_run();
  end
endmodule